// File: doc/BRIEF.md
# Dual-Region Memory Write Protector

The block sits on the path from a CPU's single-beat memory port to the memory. Each CPU write address is compared against two programmable inclusive address ranges. When an armed range matches, the write is dropped in the cycle it is presented, so it never reaches memory. One cycle later the block raises a one-cycle action pulse. Each region chooses its own action: a simulated break, a non-maskable interrupt, a trap into the hypervisor, or nothing at all.

Software programs the block through a 16-byte register window at `WIN_BASE` in the CPU address space. The window is carved out of memory, so accesses to it are never forwarded. It holds four 16-bit bounds and one control byte, and all of them are write-only. Rewriting any bound byte disarms both regions, and so does the hypervisor entry strobe. A typical sequence is to write the bounds, then write the control byte last, which arms the regions.

The CPU port follows a valid/ready handshake. A transaction completes in the cycle that `cpu_valid` and `cpu_ready` are both high. For forwarded accesses, `cpu_ready` mirrors `mem_ready`, so memory back-pressure stalls the CPU. Window accesses and blocked writes never see back-pressure: `cpu_ready` is high for them, and `mem_valid` stays low. The CPU must hold address, data and direction stable while `cpu_valid` is high and `cpu_ready` is low.

Top module: `wr_shield`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), both regions are disarmed, all bounds are zero, the three action pulses are low, and every write outside the window is forwarded to memory.
- R2: A write hits a region when that region is armed and low bound ≤ address ≤ high bound, both ends included. Addresses one below the low bound and one above the high bound do not hit.
- R3: A write that hits any armed region has `mem_valid` low and `cpu_ready` high in the same cycle, whatever the value of `mem_ready`.
- R4: The cycle after a blocked write is accepted, exactly one pulse fires for one cycle, chosen by the 3-bit action code of the winning region: 000 fires `brk_pulse`, 001 fires `nmi_pulse`, 010 fires `hyp_pulse`. Codes 011 through 111 fire nothing. With no blocked write, all pulses stay low.
- R5: When both regions hit the same write, region 0's action code decides the pulse, even if that code is no-action.
- R6: Any write to window offsets 0 through 7 disarms both regions from the next cycle on.
- R7: A high `hv_enter` at a clock edge disarms both regions from the next cycle on. It takes precedence over a control-byte write in the same cycle.
- R8: Reads are never blocked, inside or outside a range, and a disarmed region never blocks a write.
- R9: Accesses to `WIN_BASE`..`WIN_BASE+15` are not forwarded (`mem_valid` low) and complete at once. Reads there return zero. Writes to offsets 9 through 15 change nothing. Window writes are never checked against the ranges.
- R10: Accesses outside the window are forwarded with address, data and direction unchanged. `cpu_ready` equals `mem_ready`, and read data is `mem_rdata`.
- R11: Bounds are two bytes, low byte first. Region 0's low bound is at offsets 0–1 and its high bound at offsets 2–3. Region 1 uses offsets 4–5 and 6–7. The control byte at offset 8 holds region 0's arm bit in bit 0 and its action in bits 3:1, and region 1's arm bit in bit 4 and its action in bits 7:5. Writing the bytes 00 08 10 08 00 00 00 00 01 to offsets 0–8 protects 0x0800–0x0810 with the break action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hv_enter | input | 1 | Hypervisor entry strobe; disarms both regions |
| cpu_valid | input | 1 | CPU access request valid |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW (16) | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data to CPU |
| mem_valid | output | 1 | Forwarded request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_write | output | 1 | Forwarded direction |
| mem_addr | output | AW (16) | Forwarded address |
| mem_wdata | output | 8 | Forwarded write data |
| mem_rdata | input | 8 | Memory read data |
| brk_pulse | output | 1 | Simulated-break action pulse |
| nmi_pulse | output | 1 | Non-maskable interrupt action pulse |
| hyp_pulse | output | 1 | Hypervisor trap action pulse |

## Verification
If a bound or arm bit is wrong, the next write near that range shows it. A legal write can lose `mem_valid`, or a protected write can leak through, and either shows in the same cycle as the access. A wrong action field or a wrong priority between the regions shows up as the wrong pulse, or a missing one, in the single cycle after the blocked write. Sweeping every address across both edges of each range, for every action code and for overlapping ranges, exposes these faults within one access of the stored state going wrong.

// File: rtl/wr_shield_pkg.sv
package wr_shield_pkg;
  localparam int NREG     = 2;   // region count fixed by the control byte layout
  localparam int OFFW     = 4;   // register window is 2**OFFW bytes
  localparam int CTRL_OFF = 8;   // offset of the control byte
  localparam int ACTW     = 3;   // action code width

  typedef enum logic [ACTW-1:0] {
    ACT_BRK  = 3'b000,
    ACT_NMI  = 3'b001,
    ACT_HYP  = 3'b010,
    ACT_NONE = 3'b111
  } act_code_e;

  typedef struct packed {
    logic brk;
    logic nmi;
    logic hyp;
  } act_fire_t;

  function automatic act_fire_t decode_act(input logic [ACTW-1:0] code);
    act_fire_t f;
    f = '0;
    case (act_code_e'(code))
      ACT_BRK: f.brk = 1'b1;
      ACT_NMI: f.nmi = 1'b1;
      ACT_HYP: f.hyp = 1'b1;
      default: f = '0;
    endcase
    return f;
  endfunction
endpackage

// File: rtl/wr_shield_regs.sv
module wr_shield_regs
  import wr_shield_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [OFFW-1:0]          wr_off,
  input  logic [7:0]               wr_data,
  input  logic                     hv_enter,
  output logic [NREG-1:0][AW-1:0]  lo,
  output logic [NREG-1:0][AW-1:0]  hi,
  output logic [NREG-1:0]          en,
  output logic [NREG-1:0][ACTW-1:0] act
);
  localparam int NBND = 2 * NREG;  // one low and one high bound per region
  localparam int HIW  = AW - 8;    // width of the upper bound byte

  logic [NBND-1:0][AW-1:0] bnd;
  logic                    bounds_wr;
  logic                    ctrl_wr;

  assign bounds_wr = wr_en && (wr_off < OFFW'(CTRL_OFF));
  assign ctrl_wr   = wr_en && (wr_off == OFFW'(CTRL_OFF));

  // Each bound takes two consecutive offsets, low byte first.
  for (genvar i = 0; i < NBND; i++) begin : g_bnd
    localparam logic [OFFW-1:0] OFF_L = OFFW'(2 * i);
    localparam logic [OFFW-1:0] OFF_H = OFFW'(2 * i + 1);
    logic [AW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else if (wr_en) begin
        if (wr_off == OFF_L) q[7:0]    <= wr_data;
        if (wr_off == OFF_H) q[AW-1:8] <= wr_data[HIW-1:0];
      end
    end
    assign bnd[i] = q;
  end

  for (genvar r = 0; r < NREG; r++) begin : g_map
    assign lo[r] = bnd[2*r];
    assign hi[r] = bnd[2*r+1];
  end

  // Arm bits: the hypervisor strobe and bound rewrites both disarm.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en  <= '0;
      act <= '0;
    end else begin
      if (ctrl_wr) begin
        for (int r = 0; r < NREG; r++) act[r] <= wr_data[4*r+1 +: ACTW];
      end
      if (hv_enter || bounds_wr) begin
        en <= '0;
      end else if (ctrl_wr) begin
        for (int r = 0; r < NREG; r++) en[r] <= wr_data[4*r];
      end
    end
  end
endmodule

// File: rtl/wr_shield_range.sv
module wr_shield_range #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic          en,
  output logic          hit
);
  logic ge_lo;
  logic le_hi;

  assign ge_lo = (addr >= lo);
  assign le_hi = (addr <= hi);
  assign hit   = en && ge_lo && le_hi;
endmodule

// File: rtl/wr_shield_act.sv
module wr_shield_act
  import wr_shield_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fire,
  input  logic [NREG-1:0]           hit,
  input  logic [NREG-1:0][ACTW-1:0] act,
  output logic                      brk_pulse,
  output logic                      nmi_pulse,
  output logic                      hyp_pulse
);
  logic [ACTW-1:0] win_code;
  act_fire_t       nxt;

  // Lowest-numbered hitting region wins: scan from the top down.
  always_comb begin
    win_code = ACT_NONE;
    for (int r = NREG - 1; r >= 0; r--) begin
      if (hit[r]) win_code = act[r];
    end
    nxt = fire ? decode_act(win_code) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      brk_pulse <= 1'b0;
      nmi_pulse <= 1'b0;
      hyp_pulse <= 1'b0;
    end else begin
      brk_pulse <= nxt.brk;
      nmi_pulse <= nxt.nmi;
      hyp_pulse <= nxt.hyp;
    end
  end
endmodule

// File: rtl/wr_shield.sv
module wr_shield
  import wr_shield_pkg::*;
#(
  parameter int            AW       = 16,
  parameter logic [15:0]   WIN_BASE = 16'hD500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hv_enter,
  input  logic          cpu_valid,
  output logic          cpu_ready,
  input  logic          cpu_write,
  input  logic [AW-1:0] cpu_addr,
  input  logic [7:0]    cpu_wdata,
  output logic [7:0]    cpu_rdata,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          brk_pulse,
  output logic          nmi_pulse,
  output logic          hyp_pulse
);
  localparam logic [AW-OFFW-1:0] WIN_TAG = WIN_BASE[AW-1:OFFW];

  logic                      in_win;
  logic                      cfg_wr;
  logic                      blocked;
  logic [NREG-1:0]           hit_vec;
  logic [NREG-1:0][AW-1:0]   reg_lo;
  logic [NREG-1:0][AW-1:0]   reg_hi;
  logic [NREG-1:0]           reg_en;
  logic [NREG-1:0][ACTW-1:0] reg_act;

  assign in_win  = (cpu_addr[AW-1:OFFW] == WIN_TAG);
  assign cfg_wr  = cpu_valid && cpu_write && in_win;
  assign blocked = cpu_valid && cpu_write && !in_win && (|hit_vec);

  wr_shield_regs #(.AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr),
    .wr_off   (cpu_addr[OFFW-1:0]),
    .wr_data  (cpu_wdata),
    .hv_enter (hv_enter),
    .lo       (reg_lo),
    .hi       (reg_hi),
    .en       (reg_en),
    .act      (reg_act)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_rng
    wr_shield_range #(.AW(AW)) u_rng (
      .addr (cpu_addr),
      .lo   (reg_lo[r]),
      .hi   (reg_hi[r]),
      .en   (reg_en[r]),
      .hit  (hit_vec[r])
    );
  end

  wr_shield_act u_act (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (blocked),
    .hit       (hit_vec),
    .act       (reg_act),
    .brk_pulse (brk_pulse),
    .nmi_pulse (nmi_pulse),
    .hyp_pulse (hyp_pulse)
  );

  // Forwarding path: window and blocked writes complete locally.
  assign mem_valid = cpu_valid && !in_win && !blocked;
  assign mem_write = cpu_write;
  assign mem_addr  = cpu_addr;
  assign mem_wdata = cpu_wdata;
  assign cpu_ready = (in_win || blocked) ? 1'b1 : mem_ready;
  assign cpu_rdata = in_win ? 8'h00 : mem_rdata;
endmodule

// File: rtl/wr_shield_chk.sv
module wr_shield_chk
  import wr_shield_pkg::*;
#(
  parameter int          AW       = 16,
  parameter logic [15:0] WIN_BASE = 16'hD500
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    hv_enter,
  input logic                    cpu_valid,
  input logic                    cpu_ready,
  input logic                    cpu_write,
  input logic [AW-1:0]           cpu_addr,
  input logic [7:0]              cpu_rdata,
  input logic                    mem_valid,
  input logic                    mem_ready,
  input logic                    brk_pulse,
  input logic                    nmi_pulse,
  input logic                    hyp_pulse,
  input logic [NREG-1:0][AW-1:0] reg_lo,
  input logic [NREG-1:0][AW-1:0] reg_hi,
  input logic [NREG-1:0]         reg_en
);
  logic win;
  logic prot;
  logic prev_prot;

  assign win = (cpu_addr[AW-1:OFFW] == WIN_BASE[AW-1:OFFW]);

  always_comb begin
    prot = 1'b0;
    for (int r = 0; r < NREG; r++) begin
      if (reg_en[r] && reg_lo[r] <= cpu_addr && cpu_addr <= reg_hi[r]) prot = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_prot <= 1'b0;
    else        prev_prot <= cpu_valid && cpu_write && !win && prot;
  end

  p_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_write && !win && prot) |-> (!mem_valid && cpu_ready));

  p_pulse_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({brk_pulse, nmi_pulse, hyp_pulse}));

  p_pulse_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_pulse || nmi_pulse || hyp_pulse) |-> prev_prot);

  p_bound_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_write && win && cpu_addr[OFFW-1:0] < OFFW'(CTRL_OFF)) |=> (reg_en == '0));

  p_hv_disarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hv_enter |=> (reg_en == '0));

  p_read_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !cpu_write && !win) |-> mem_valid);

  p_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && win) |-> (!mem_valid && cpu_ready && cpu_rdata == 8'h00));

  p_ready_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !win && !(cpu_write && prot)) |-> (cpu_ready == mem_ready));
endmodule

bind wr_shield wr_shield_chk #(.AW(AW), .WIN_BASE(WIN_BASE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hv_enter  (hv_enter),
  .cpu_valid (cpu_valid),
  .cpu_ready (cpu_ready),
  .cpu_write (cpu_write),
  .cpu_addr  (cpu_addr),
  .cpu_rdata (cpu_rdata),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .brk_pulse (brk_pulse),
  .nmi_pulse (nmi_pulse),
  .hyp_pulse (hyp_pulse),
  .reg_lo    (reg_lo),
  .reg_hi    (reg_hi),
  .reg_en    (reg_en)
);

// File: tb/tb_wr_shield.sv
module tb_wr_shield;
  localparam logic [15:0] WB = 16'hD500;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hv_enter = 1'b0;
  logic        cpu_valid = 1'b0;
  logic        cpu_write = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        mem_ready = 1'b1;
  logic        cpu_ready, mem_valid, mem_write;
  logic [7:0]  cpu_rdata, mem_wdata;
  logic [15:0] mem_addr;
  logic        brk_pulse, nmi_pulse, hyp_pulse;
  logic [7:0]  mem_rdata;

  assign mem_rdata = mem_addr[7:0] ^ 8'h5A;

  always #5 clk = ~clk;

  wr_shield #(.AW(16), .WIN_BASE(WB)) dut (
    .clk(clk), .rst_n(rst_n), .hv_enter(hv_enter),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_write(cpu_write),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .brk_pulse(brk_pulse), .nmi_pulse(nmi_pulse), .hyp_pulse(hyp_pulse)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Bench model of the register file, built from the requirements.
  logic [15:0] m_lo [2];
  logic [15:0] m_hi [2];
  logic        m_en [2];
  logic [2:0]  m_act [2];

  task automatic chk(input logic ok, input string req, input int act_v, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  function automatic logic in_rng(input int r, input logic [15:0] a);
    return m_en[r] && (a >= m_lo[r]) && (a <= m_hi[r]);
  endfunction

  // 0 none, 1 brk, 2 nmi, 3 hyp
  function automatic int code_to_pulse(input logic [2:0] c);
    case (c)
      3'b000: return 1;
      3'b001: return 2;
      3'b010: return 3;
      default: return 0;
    endcase
  endfunction

  task automatic model_cfg(input logic [3:0] off, input logic [7:0] d);
    if (off < 4'd8) begin
      int r = off / 4;
      if (off[1] == 1'b0) begin
        if (off[0] == 1'b0) m_lo[r][7:0] = d; else m_lo[r][15:8] = d;
      end else begin
        if (off[0] == 1'b0) m_hi[r][7:0] = d; else m_hi[r][15:8] = d;
      end
      m_en[0] = 1'b0; m_en[1] = 1'b0;
    end else if (off == 4'd8) begin
      m_en[0] = d[0]; m_act[0] = d[3:1];
      m_en[1] = d[4]; m_act[1] = d[7:5];
    end
  endtask

  task automatic acc(input logic w, input logic [15:0] a, input logic [7:0] d, input string req);
    logic win, blk;
    int   exp_p, got_p;
    win = (a[15:4] == WB[15:4]);
    blk = w && !win && (in_rng(0, a) || in_rng(1, a));
    exp_p = 0;
    if (blk) exp_p = in_rng(0, a) ? code_to_pulse(m_act[0]) : code_to_pulse(m_act[1]);
    cpu_valid = 1'b1; cpu_write = w; cpu_addr = a; cpu_wdata = d;
    #1;
    chk(mem_valid == (!win && !blk), req, mem_valid, !win && !blk);
    chk(cpu_ready == ((win || blk) ? 1'b1 : mem_ready), req, cpu_ready, (win || blk) ? 1 : mem_ready);
    if (!w) chk(cpu_rdata == (win ? 8'h00 : (a[7:0] ^ 8'h5A)), req, cpu_rdata, win ? 0 : (a[7:0] ^ 8'h5A));
    if (mem_valid) chk(mem_addr == a && mem_write == w && mem_wdata == d, "R10", mem_addr, a);
    @(posedge clk);
    @(negedge clk);
    cpu_valid = 1'b0;
    if (win && w) model_cfg(a[3:0], d);
    got_p = brk_pulse ? 1 : nmi_pulse ? 2 : hyp_pulse ? 3 : 0;
    chk(got_p == exp_p && (32'(brk_pulse) + nmi_pulse + hyp_pulse) <= 1, req, got_p, exp_p);
  endtask

  task automatic cfg9(input logic [15:0] lo0, input logic [15:0] hi0,
                      input logic [15:0] lo1, input logic [15:0] hi1, input logic [7:0] ctl);
    acc(1'b1, WB + 16'd0, lo0[7:0],  "R11");
    acc(1'b1, WB + 16'd1, lo0[15:8], "R11");
    acc(1'b1, WB + 16'd2, hi0[7:0],  "R11");
    acc(1'b1, WB + 16'd3, hi0[15:8], "R11");
    acc(1'b1, WB + 16'd4, lo1[7:0],  "R11");
    acc(1'b1, WB + 16'd5, lo1[15:8], "R11");
    acc(1'b1, WB + 16'd6, hi1[7:0],  "R11");
    acc(1'b1, WB + 16'd7, hi1[15:8], "R11");
    acc(1'b1, WB + 16'd8, ctl,       "R11");
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int r = 0; r < 2; r++) begin m_lo[r] = '0; m_hi[r] = '0; m_en[r] = 1'b0; m_act[r] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state at the ports
    chk(!mem_valid && !brk_pulse && !nmi_pulse && !hyp_pulse, "R1", mem_valid, 0);
    for (int a = 16'h0000; a < 16'h0010; a++) acc(1'b1, 16'(a), 8'h11, "R1");

    // R11 / R2 / R3 / R4: the example setting, swept across both edges
    cfg9(16'h0800, 16'h0810, 16'h0000, 16'h0000, 8'h01);
    for (int a = 16'h07F0; a <= 16'h0820; a++) acc(1'b1, 16'(a), 8'h22, "R2");
    // R8: reads inside the protected range pass
    for (int a = 16'h0800; a <= 16'h0810; a++) acc(1'b0, 16'(a), 8'h00, "R8");

    // R4: every action code, each region on its own
    for (int c = 0; c < 8; c++) begin
      acc(1'b1, WB + 16'd8, {4'b0000, 3'(c), 1'b1}, "R4");
      acc(1'b1, 16'h0805, 8'h33, "R4");
    end
    cfg9(16'h0800, 16'h0810, 16'h0900, 16'h09FF, 8'h00);
    for (int c = 0; c < 8; c++) begin
      acc(1'b1, WB + 16'd8, {3'(c), 1'b1, 4'b0000}, "R4");
      acc(1'b1, 16'h0950, 8'h44, "R4");
      acc(1'b1, 16'h0805, 8'h44, "R8");
    end

    // R5: overlap, region 0 hyp and region 1 nmi; then region 0 no-action
    cfg9(16'h0800, 16'h0810, 16'h0808, 16'h0900, {3'b001, 1'b1, 3'b010, 1'b1});
    for (int a = 16'h07F8; a <= 16'h0908; a++) acc(1'b1, 16'(a), 8'h55, "R5");
    acc(1'b1, WB + 16'd8, {3'b001, 1'b1, 3'b111, 1'b1}, "R5");
    acc(1'b1, 16'h080A, 8'h55, "R5");
    acc(1'b1, 16'h0880, 8'h55, "R5");

    // R6: rewriting a bound byte with the same value disarms both
    acc(1'b1, WB + 16'd3, 8'h08, "R6");
    acc(1'b1, 16'h0805, 8'h66, "R6");
    acc(1'b1, 16'h0880, 8'h66, "R6");

    // R7: hypervisor entry disarms, and beats a simultaneous control write
    acc(1'b1, WB + 16'd8, 8'h11, "R7");
    acc(1'b1, 16'h0805, 8'h77, "R7");
    hv_enter = 1'b1;
    @(posedge clk); @(negedge clk);
    hv_enter = 1'b0;
    m_en[0] = 1'b0; m_en[1] = 1'b0;
    acc(1'b1, 16'h0805, 8'h77, "R7");
    hv_enter = 1'b1;
    acc(1'b1, WB + 16'd8, 8'h11, "R7");
    hv_enter = 1'b0;
    m_en[0] = 1'b0; m_en[1] = 1'b0;
    acc(1'b1, 16'h0805, 8'h77, "R7");

    // R9: window reads are zero, high offsets inert, window writes unchecked
    acc(1'b1, WB + 16'd8, 8'h11, "R9");
    for (int o = 0; o < 16; o++) acc(1'b0, WB + 16'(o), 8'h00, "R9");
    for (int o = 9; o < 16; o++) acc(1'b1, WB + 16'(o), 8'hFF, "R9");
    acc(1'b1, 16'h0805, 8'h88, "R9");
    acc(1'b1, 16'h0880, 8'h88, "R9");

    // R10 / R3: back-pressure
    mem_ready = 1'b0;
    acc(1'b1, 16'h0100, 8'h99, "R10");
    acc(1'b0, 16'h0101, 8'h00, "R10");
    acc(1'b1, 16'h0808, 8'h99, "R3");
    mem_ready = 1'b1;

    // R2 / R8: near-exhaustive sweep with ranges at the address-space ends
    cfg9(16'h0000, 16'h0003, 16'hFFFC, 16'hFFFF, {3'b010, 1'b1, 3'b000, 1'b1});
    for (int a = 0; a < 4096; a++) acc(1'b1, 16'(a), 8'hA0, "R2");
    for (int a = 16'hF000; a <= 16'hFFFF; a++) acc(a[0] ? 1'b1 : 1'b0, 16'(a), 8'hB0, "R2");
    cfg9(16'h0000, 16'h0003, 16'hFFFC, 16'hFFFF, {3'b010, 1'b0, 3'b000, 1'b0});
    for (int a = 16'hFFF0; a <= 16'hFFFF; a++) acc(1'b1, 16'(a), 8'hC0, "R8");

    finish_run();
  end
endmodule